// File: doc/BRIEF.md
# Weighted Random Spectral Mixer

This block drives one input of a circuit under test during sequential self-test. It takes up to three spectral-component bit-streams meant for that input. Each stream is a periodic waveform made from Walsh functions. The block merges them into a single stream by random selection with fixed proportions, and it then corrupts the merged bit with sparse random noise. All of the randomness comes from a small cellular-automaton register. One cell of that register gives a stream with weight one half. ANDing two cells gives a stream with weight one quarter.

A mode input sets how many components are active. With one component, that component goes straight to the noise stage. With two, a weight-0.5 bit chooses one of the pair. With three, a two-level tree takes the third component half the time and divides the other half equally between the first and second. The noise stage inverts the chosen bit whenever the weight-0.25 noise stream is 1. The automaton and the output register move forward only when the self-test step strobe is high, so the generated stream follows the divided test clock and not the system clock.

Top module: `spectral_noise_mixer`

## Requirements
- R1: During reset and after reset is released, `tst_bit_o` is 0. Before the first step, the automaton holds `seed_i`. If `seed_i` is all zeros, it holds the parameter `SAFE_SEED` instead (default 8'h01).
- R2: On each clock with `step_i` high, every automaton cell i becomes left XOR right XOR (own value if bit i of `RULE_MASK` is 1). Left is cell i+1 and right is cell i-1. A neighbour outside the register counts as 0. The defaults are an 8-cell register and `RULE_MASK` = 8'h05.
- R3: On a clock with `step_i` low, neither the automaton nor `tst_bit_o` changes, whatever values the component and mode inputs have.
- R4: With `mode_i` equal to 0 or 1, the mixed bit is `sc_i[0]`.
- R5: With `mode_i` equal to 2, the mixed bit is `sc_i[1]` when automaton cell 0 is 1, and `sc_i[0]` when cell 0 is 0.
- R6: With `mode_i` equal to 3, the mixed bit is `sc_i[2]` when cell 0 is 1. Otherwise it is `sc_i[1]` when cell 1 is 1, and `sc_i[0]` when cell 1 is 0.
- R7: The noise bit is the AND of automaton cells 2 and 3. The output bit is the mixed bit XOR the noise bit.
- R8: On a stepping clock edge, `tst_bit_o` takes the R7 result computed from the automaton state and inputs present just before that edge. The automaton advances on the same edge.
- R9: Once reset has ended, the automaton never holds all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| step_i | input | 1 | Self-test step strobe, the clock enable for all state |
| mode_i | input | 2 | Number of active components: 0 or 1 means one, 2 means two, 3 means three |
| sc_i | input | 3 | Component bits; bit 0 is the first component |
| seed_i | input | 8 | Automaton seed, loaded while reset is asserted |
| tst_bit_o | output | 1 | Noisy mixed bit driven to the circuit under test |

## Verification
The main path is run with a fixed table of steps. The table cycles through every mode with component patterns in which the three bits differ, such as 001, 010, 100, 011 and 110. Every expected output therefore shows which component was selected and whether noise flipped it. Patterns that set all components equal (000 and 111) leave the selection out of the result and test the noise inversion alone. A pause with the strobe low, while the components toggle, is followed by more steps against the model. This separates a stalled automaton from one that ran on during the pause. A second reset with an all-zero seed checks the substituted seed over several steps.

// File: rtl/snm_pkg.sv
package snm_pkg;
  typedef enum logic [1:0] {
    MIX_SINGLE0 = 2'd0,
    MIX_SINGLE  = 2'd1,
    MIX_PAIR    = 2'd2,
    MIX_TRIO    = 2'd3
  } mix_mode_e;

  localparam int unsigned NUM_SC = 3;
endpackage

// File: rtl/snm_rst_sync.sv
module snm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/snm_ca_reg.sv
module snm_ca_reg #(
  parameter int unsigned       CA_W      = 8,
  parameter logic [CA_W-1:0]   RULE_MASK = 8'h05,
  parameter logic [CA_W-1:0]   SAFE_SEED = 8'h01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [CA_W-1:0] seed,
  output logic [CA_W-1:0] state
);
  logic [CA_W-1:0] state_q;
  logic [CA_W-1:0] state_d;
  logic [CA_W-1:0] evolved;
  logic [CA_W-1:0] load_val;

  assign load_val = (seed == '0) ? SAFE_SEED : seed;

  for (genvar i = 0; i < CA_W; i++) begin : g_cell
    logic left_nb;
    logic right_nb;
    if (i == CA_W - 1) begin : g_top
      assign left_nb = 1'b0;
    end else begin : g_mid_l
      assign left_nb = state_q[i+1];
    end
    if (i == 0) begin : g_bot
      assign right_nb = 1'b0;
    end else begin : g_mid_r
      assign right_nb = state_q[i-1];
    end
    assign evolved[i] = left_nb ^ right_nb ^ (RULE_MASK[i] & state_q[i]);
  end

  always_comb begin
    state_d = state_q;
    if (step) state_d = evolved;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= load_val;
    else        state_q <= state_d;
  end

  assign state = state_q;

  AST_CA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state_q)) else $error("automaton moved without step"); // R3

  AST_CA_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0) else $error("automaton reached all zeros"); // R9
endmodule

// File: rtl/snm_selector.sv
module snm_selector
  import snm_pkg::*;
(
  input  mix_mode_e         mode,
  input  logic [NUM_SC-1:0] sc,
  input  logic              sel_hi,
  input  logic              sel_lo,
  output logic              mixed
);
  logic pair_pick;

  assign pair_pick = sel_lo ? sc[1] : sc[0];

  always_comb begin
    unique case (mode)
      MIX_PAIR: mixed = sel_hi ? sc[1] : sc[0];
      MIX_TRIO: mixed = sel_hi ? sc[2] : pair_pick;
      default:  mixed = sc[0];
    endcase
  end
endmodule

// File: rtl/snm_noise_stage.sv
module snm_noise_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic bit_in,
  input  logic noise,
  output logic bit_out
);
  logic out_q;
  logic out_d;

  always_comb begin
    out_d = out_q;
    if (step) out_d = bit_in ^ noise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign bit_out = out_q;

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(out_q)) else $error("output moved without step"); // R3

  AST_NOISE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && noise) |=> (out_q != $past(bit_in))) else $error("noise did not invert"); // R7

  AST_NOISE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !noise) |=> (out_q == $past(bit_in))) else $error("clean bit altered"); // R7
endmodule

// File: rtl/spectral_noise_mixer.sv
module spectral_noise_mixer
  import snm_pkg::*;
#(
  parameter int unsigned     CA_W      = 8,
  parameter logic [CA_W-1:0] RULE_MASK = 8'h05,
  parameter logic [CA_W-1:0] SAFE_SEED = 8'h01,
  parameter int unsigned     SEL_HI_TAP = 0,
  parameter int unsigned     SEL_LO_TAP = 1,
  parameter int unsigned     NZ_TAP_A   = 2,
  parameter int unsigned     NZ_TAP_B   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic [1:0]        mode_i,
  input  logic [NUM_SC-1:0] sc_i,
  input  logic [CA_W-1:0]   seed_i,
  output logic              tst_bit_o
);
  logic            rst_n_int;
  logic [CA_W-1:0] ca_state;
  logic            mixed_bit;
  logic            noise_bit;
  mix_mode_e       mode_e;

  assign mode_e    = mix_mode_e'(mode_i);
  assign noise_bit = ca_state[NZ_TAP_A] & ca_state[NZ_TAP_B];

  snm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  snm_ca_reg #(
    .CA_W      (CA_W),
    .RULE_MASK (RULE_MASK),
    .SAFE_SEED (SAFE_SEED)
  ) u_ca (
    .clk   (clk),
    .rst_n (rst_n_int),
    .step  (step_i),
    .seed  (seed_i),
    .state (ca_state)
  );

  snm_selector u_sel (
    .mode   (mode_e),
    .sc     (sc_i),
    .sel_hi (ca_state[SEL_HI_TAP]),
    .sel_lo (ca_state[SEL_LO_TAP]),
    .mixed  (mixed_bit)
  );

  snm_noise_stage u_noise (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .step    (step_i),
    .bit_in  (mixed_bit),
    .noise   (noise_bit),
    .bit_out (tst_bit_o)
  );

  AST_SINGLE_PASS: assert property (@(posedge clk) disable iff (!rst_n_int)
    (step_i && !mode_i[1] && !noise_bit) |=> (tst_bit_o == $past(sc_i[0])))
    else $error("single mode did not pass component"); // R4

  AST_PAIR_PICK: assert property (@(posedge clk) disable iff (!rst_n_int)
    (step_i && mode_i == 2'd2 && !noise_bit) |=>
      (tst_bit_o == ($past(ca_state[SEL_HI_TAP]) ? $past(sc_i[1]) : $past(sc_i[0]))))
    else $error("pair selection wrong"); // R5

  AST_TRIO_THIRD: assert property (@(posedge clk) disable iff (!rst_n_int)
    (step_i && mode_i == 2'd3 && ca_state[SEL_HI_TAP] && !noise_bit) |=>
      (tst_bit_o == $past(sc_i[2])))
    else $error("trio did not take third component"); // R6
endmodule

// File: tb/tb_spectral_noise_mixer.sv
module tb_spectral_noise_mixer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       step_i;
  logic [1:0] mode_i;
  logic [2:0] sc_i;
  logic [7:0] seed_i;
  logic       tst_bit_o;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model_ca;

  localparam logic [7:0] MASK = 8'h05;
  localparam int NVEC = 20;
  localparam logic [4:0] VEC [NVEC] = '{
    5'b01_001, 5'b01_000, 5'b00_001, 5'b10_001, 5'b10_010,
    5'b10_011, 5'b11_001, 5'b11_010, 5'b11_100, 5'b11_110,
    5'b11_011, 5'b10_101, 5'b11_000, 5'b11_111, 5'b01_111,
    5'b10_100, 5'b11_101, 5'b00_110, 5'b11_100, 5'b10_010
  };

  always #10 clk = ~clk;

  spectral_noise_mixer dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .mode_i(mode_i),
    .sc_i(sc_i), .seed_i(seed_i), .tst_bit_o(tst_bit_o)
  );

  function automatic logic [7:0] ca_adv(input logic [7:0] s);
    logic [7:0] n;
    for (int i = 0; i < 8; i++) begin
      logic l, r;
      l = (i == 7) ? 1'b0 : s[i+1];
      r = (i == 0) ? 1'b0 : s[i-1];
      n[i] = l ^ r ^ (MASK[i] & s[i]);
    end
    return n;
  endfunction

  function automatic logic predict(input logic [7:0] s, input logic [1:0] m,
                                   input logic [2:0] c);
    logic mx;
    case (m)
      2'd2:    mx = s[0] ? c[1] : c[0];
      2'd3:    mx = s[0] ? c[2] : (s[1] ? c[1] : c[0]);
      default: mx = c[0];
    endcase
    return mx ^ (s[2] & s[3]);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: tst_bit_o=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_step(input logic [1:0] m, input logic [2:0] c, input string tag);
    logic e;
    @(negedge clk);
    mode_i = m; sc_i = c; step_i = 1'b1;
    e = predict(model_ca, m, c);
    @(negedge clk);
    step_i = 1'b0;
    model_ca = ca_adv(model_ca);
    check(tag, tst_bit_o, e);
  endtask

  task automatic do_reset(input logic [7:0] s);
    @(negedge clk);
    rst_n = 1'b0; step_i = 1'b0; seed_i = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_ca = (s == 8'h00) ? 8'h01 : s;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    string tag;
    logic held;
    rst_n = 1'b0; step_i = 1'b0; mode_i = 2'd0; sc_i = 3'b000; seed_i = 8'hB4;
    do_reset(8'hB4);
    check("R1 reset output", tst_bit_o, 1'b0);

    // R2 R7 R8: automaton model drives selection and noise every step
    for (int k = 0; k < NVEC; k++) begin
      case (VEC[k][4:3])
        2'd2:    tag = "R5 pair select (R2 R7 R8)";
        2'd3:    tag = "R6 trio select (R2 R7 R8)";
        default: tag = "R4 single pass (R2 R7 R8)";
      endcase
      do_step(VEC[k][4:3], VEC[k][2:0], tag);
    end

    // R3: strobe low, inputs toggle, nothing may move
    held = tst_bit_o;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      mode_i = 2'(k); sc_i = ~sc_i;
      @(negedge clk);
      check("R3 hold output", tst_bit_o, held);
    end
    for (int k = 0; k < 4; k++) do_step(2'd3, 3'(k + 3), "R3 R6 resume after hold");

    // R1 R9: all-zero seed replaced by safe seed
    do_reset(8'h00);
    check("R1 reset output zero seed", tst_bit_o, 1'b0);
    for (int k = 0; k < 6; k++) do_step(2'd3, 3'b110 ^ 3'(k), "R1 R9 safe seed run");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule